// File: doc/BRIEF.md
# Seven-Segment Digit Decoder Chain with Zero Suppression

This block turns a row of binary-coded decimal digits into segment drives for a multi-digit seven-segment display. Each digit position has a small decoder. It maps the values 0 to 9 to their glyphs and leaves the display dark for the six unused codes. It also has a forced-blank input, a lamp-test input and a ripple-blanking path. Through that path a zero digit can go dark when every digit above it is also a suppressed zero. The digit positions are chained from the most significant to the least significant, so a value such as 0077 shows as two dark positions followed by 7 and 7.

A shared latch-enable controls the capture of all digit nibbles. While the enable is high, the input nibbles pass straight to the decoders in the same cycle, and they are also captured on every clock edge. While the enable is low, each position shows the nibble it captured at the last edge where the enable was high. A build-time parameter inverts every segment for common-anode displays. The decimal point and time-multiplexed scanning are handled elsewhere.

Top module: `bcd7_display_chain`

## Requirements
- R1: The segment vector for one digit is 7 bits, with bit 0 driving segment a and bit 6 driving segment g; segments are active high by default. Values 0 to 9 give these hex codes, in digit order: 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. Digit i of the top occupies seg_out[7*i+6:7*i] and takes bcd_in[4*i+3:4*i], where digit 0 is least significant.
- R2: A digit value from 10 to 15 drives all seven segments off.
- R3: With lamp test inactive, a low blank_n turns every segment of every digit off, whatever the data and ripple inputs are.
- R4: When a digit's ripple input is low and its displayed value is 0, that digit is dark. When the ripple input is low and the value is nonzero, the digit shows its glyph.
- R5: A digit's ripple output is low exactly when its ripple input is low and its displayed value is 0. Lamp test and forced blanking do not change it.
- R6: The most significant digit takes ripple_in_n, each lower digit takes the ripple output of the digit above, and ripple_out_n is the ripple output of digit 0. This suppresses leading zeros: with ripple_in_n low, 0077 shows dark, dark, 7, 7, and 0707 shows dark, 7, 0, 7.
- R7: A low lamp_test_n lights all seven segments of every digit. It overrides blank_n and ripple blanking.
- R8: While latch_en is high, the display follows bcd_in in the same cycle. While latch_en is low, each digit displays the nibble present at the last rising clock edge at which latch_en was high.
- R9: After reset, the stored nibbles are 0, so with latch_en low every digit displays 0 (subject to blanking).
- R10: With ACTIVE_LOW set to 1, every segment output is the bitwise inverse of the active-high value for the same inputs. The ripple output is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the input capture registers |
| rst_n | input | 1 | Asynchronous active-low reset; clears the stored nibbles |
| latch_en | input | 1 | 1: inputs pass through and are captured; 0: stored nibbles are shown |
| bcd_in | input | 4*DIGITS | Digit nibbles; nibble 0 is least significant |
| blank_n | input | 1 | Active-low forced blank of all digits |
| ripple_in_n | input | 1 | Active-low ripple-blanking input of the most significant digit |
| lamp_test_n | input | 1 | Active-low lamp test; lights every segment |
| seg_out | output | 7*DIGITS | Segment drives, 7 bits per digit, bit 0 = segment a |
| ripple_out_n | output | 1 | Ripple-blanking output of the least significant digit |

## Verification
The assertions check the following on every cycle, for each digit position:
- lamp test lights everything;
- forced blanking and out-of-range codes leave the digit dark;
- a low ripple output only ever comes from a zero digit whose ripple input is low;
- the shown value holds steady while the latch is closed;
- the chain output is never low unless the chain input is low.

The correct glyph for each value cannot be shown by these properties; only the bench's scenarios can show it. The same is true of the exact leading-zero pattern across several digits, the timing of which edge captures a nibble, and the inverted polarity variant. For these, the bench compares full segment vectors against a model worked out from the requirements.

// File: rtl/seg7_digit.sv
module seg7_digit #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       le,
  input  logic [3:0] bcd,
  input  logic       bl_n,
  input  logic       rbi_n,
  input  logic       lt_n,
  output logic [6:0] seg,
  output logic       rbo_n
);
  logic [3:0] held;
  logic [3:0] cur;
  logic [6:0] glyph;
  logic [6:0] lit;
  logic       zero_sup;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  held <= '0;
    else if (le) held <= bcd;

  assign cur = le ? bcd : held;

  always_comb begin
    case (cur)
      4'd0: glyph = 7'h3F;
      4'd1: glyph = 7'h06;
      4'd2: glyph = 7'h5B;
      4'd3: glyph = 7'h4F;
      4'd4: glyph = 7'h66;
      4'd5: glyph = 7'h6D;
      4'd6: glyph = 7'h7D;
      4'd7: glyph = 7'h07;
      4'd8: glyph = 7'h7F;
      4'd9: glyph = 7'h6F;
      default: glyph = 7'h00;
    endcase
  end

  assign zero_sup = !rbi_n && (cur == 4'd0);

  always_comb begin
    if (!lt_n)                 lit = 7'h7F;
    else if (!bl_n || zero_sup) lit = 7'h00;
    else                       lit = glyph;
  end

  assign seg   = ACTIVE_LOW ? ~lit : lit;
  assign rbo_n = !zero_sup;

  AST_LAMP_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !lt_n |-> lit == 7'h7F); // R7
  AST_FORCED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_n && !bl_n) |-> lit == 7'h00); // R3
  AST_BAD_CODE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_n && cur > 4'd9) |-> lit == 7'h00); // R2
  AST_RIPPLE_OUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !rbo_n |-> (!rbi_n && cur == 4'd0)); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && $past(!le)) |-> $stable(cur)); // R8
endmodule

// File: rtl/bcd7_display_chain.sv
module bcd7_display_chain #(
  parameter int DIGITS     = 4,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  latch_en,
  input  logic [4*DIGITS-1:0]   bcd_in,
  input  logic                  blank_n,
  input  logic                  ripple_in_n,
  input  logic                  lamp_test_n,
  output logic [7*DIGITS-1:0]   seg_out,
  output logic                  ripple_out_n
);
  logic [DIGITS:0] chain;

  assign chain[DIGITS] = ripple_in_n;
  assign ripple_out_n  = chain[0];

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    seg7_digit #(.ACTIVE_LOW(ACTIVE_LOW)) u_digit (
      .clk   (clk),
      .rst_n (rst_n),
      .le    (latch_en),
      .bcd   (bcd_in[4*i +: 4]),
      .bl_n  (blank_n),
      .rbi_n (chain[i+1]),
      .lt_n  (lamp_test_n),
      .seg   (seg_out[7*i +: 7]),
      .rbo_n (chain[i])
    );
  end

  AST_CHAIN_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !ripple_out_n |-> !ripple_in_n); // R6
endmodule

// File: tb/bcd7_display_chain_tb_top.sv
module bcd7_display_chain_tb_top;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic latch_en = 1'b0;
  logic [4*D-1:0] bcd_in = '0;
  logic blank_n = 1'b1, ripple_in_n = 1'b1, lamp_test_n = 1'b1;
  logic [7*D-1:0] seg_out, seg_out_al;
  logic ripple_out_n, ripple_out_al;

  int checks = 0, failures = 0;
  logic [15:0] tb_held = '0;

  logic [7*D-1:0] q_seg[$];
  logic           q_rbo[$];
  string          q_tag[$];

  always #4 clk = ~clk;

  bcd7_display_chain #(.DIGITS(D), .ACTIVE_LOW(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .bcd_in(bcd_in),
    .blank_n(blank_n), .ripple_in_n(ripple_in_n), .lamp_test_n(lamp_test_n),
    .seg_out(seg_out), .ripple_out_n(ripple_out_n));

  bcd7_display_chain #(.DIGITS(D), .ACTIVE_LOW(1'b1)) dut_al (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .bcd_in(bcd_in),
    .blank_n(blank_n), .ripple_in_n(ripple_in_n), .lamp_test_n(lamp_test_n),
    .seg_out(seg_out_al), .ripple_out_n(ripple_out_al));

  function automatic logic [6:0] glyph_of(input logic [3:0] v);
    case (v)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic drive(input logic le, input logic [15:0] d, input logic bl,
                       input logic rbi, input logic lt, input string tag);
    logic [15:0] shown;
    logic [7*D-1:0] exp_seg;
    logic r;
    @(negedge clk);
    latch_en = le; bcd_in = d; blank_n = bl; ripple_in_n = rbi; lamp_test_n = lt;
    shown = le ? d : tb_held;
    r = rbi;
    for (int i = D - 1; i >= 0; i--) begin
      logic [3:0] v;
      logic zs;
      v  = shown[4*i +: 4];
      zs = !r && (v == 4'd0);
      if (!lt)            exp_seg[7*i +: 7] = 7'h7F;
      else if (!bl || zs) exp_seg[7*i +: 7] = 7'h00;
      else                exp_seg[7*i +: 7] = glyph_of(v);
      r = !zs;
    end
    q_seg.push_back(exp_seg);
    q_rbo.push_back(r);
    q_tag.push_back(tag);
    if (le) tb_held = d;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #3;
      if (q_seg.size() > 0) begin
        logic [7*D-1:0] es;
        logic er;
        string t;
        es = q_seg.pop_front(); er = q_rbo.pop_front(); t = q_tag.pop_front();
        checks++;
        if (seg_out !== es || ripple_out_n !== er) begin
          failures++;
          $display("FAIL %s: seg=%h rbo=%b expected seg=%h rbo=%b", t, seg_out, ripple_out_n, es, er);
        end
        checks++;
        if (seg_out_al !== ~es || ripple_out_al !== er) begin
          failures++;
          $display("FAIL R10 (%s): seg=%h rbo=%b expected seg=%h rbo=%b", t, seg_out_al, ripple_out_al, ~es, er);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    drive(1'b0, 16'h1234, 1'b1, 1'b1, 1'b1, "R9 reset shows zeros");
    for (int v = 0; v < 16; v++)
      drive(1'b1, {4{v[3:0]}}, 1'b1, 1'b1, 1'b1, v < 10 ? "R1 glyph" : "R2 invalid dark");
    drive(1'b1, 16'h0077, 1'b1, 1'b0, 1'b1, "R6 0077");
    drive(1'b1, 16'h0707, 1'b1, 1'b0, 1'b1, "R6 0707");
    drive(1'b1, 16'h0000, 1'b1, 1'b0, 1'b1, "R5 all zero chain");
    drive(1'b1, 16'h5000, 1'b1, 1'b0, 1'b1, "R4 nonzero with ripple low");
    drive(1'b1, 16'h0000, 1'b1, 1'b1, 1'b1, "R4 zeros with ripple high");
    drive(1'b1, 16'h00A0, 1'b1, 1'b0, 1'b1, "R5 invalid stops chain");
    drive(1'b1, 16'h1234, 1'b0, 1'b1, 1'b1, "R3 forced blank");
    drive(1'b1, 16'h0000, 1'b0, 1'b0, 1'b1, "R5 blank keeps ripple");
    drive(1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, "R7 lamp over ripple");
    drive(1'b1, 16'h9F12, 1'b0, 1'b1, 1'b0, "R7 lamp over blank");
    drive(1'b1, 16'h5678, 1'b1, 1'b1, 1'b1, "R8 transparent");
    drive(1'b0, 16'h9999, 1'b1, 1'b1, 1'b1, "R8 hold");
    drive(1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, "R8 hold ignores input");
    drive(1'b1, 16'h0304, 1'b1, 1'b0, 1'b1, "R8 reopen");
    drive(1'b0, 16'h7777, 1'b1, 1'b0, 1'b1, "R6 held value chain");
    for (int k = 0; k < 10; k++)
      drive(1'b1, {k[3:0], 4'd0, k[3:0], 4'd0}, 1'b1, 1'b0, 1'b1, "R6 mixed zeros");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule